// File: doc/BRIEF.md
# Masked S-box Exponentiation Sequencer

This block evaluates the AES substitution box on a byte that arrives split into ORDER+1 Boolean shares, whose XOR is the secret byte. The shares are never combined inside the block. The field inverse is formed as the 254th power. A fixed chain of share-wise power maps, two mask refreshes and four masked field multiplications produces it. All four multiplications go through one shared multiplier instance. The affine output map is then applied to each share on its own.

A caller presents the input shares and pulses `start_i`. The block takes fresh random bytes on `rnd_i` in every cycle of the chain. After a fixed latency it raises `done_o` for one cycle. At that point `y_sh_o` holds output shares whose XOR is the S-box value. The shares stay on `y_sh_o` until the next operation finishes. The masking order is a parameter. The three share registers (square, fourth-power and running product) are sized from it.

Top module: `masked_sbox_seq`

## Requirements
- R1: For every input byte and every input sharing, the XOR of the output shares equals the AES S-box of the XOR of the input shares.
- R2: An input whose shares XOR to 0x00 gives output shares that XOR to 0x63.
- R3: `done_o` is high for exactly one cycle, 10 clock edges after the edge that accepts `start_i`.
- R4: A `start_i` pulse that arrives while an operation is running has no effect: the running result, its latency and the count of `done_o` pulses are unchanged.
- R5: Each mask refresh leaves the value carried by the refreshed share vector unchanged.
- R6: The masked multiplier's output shares XOR to the field product (polynomial 0x11B) of the XORs of its two operand vectors.
- R7: `y_sh_o` holds its value in every cycle except the one that completes an operation.
- R8: In reset, `done_o` is 0 and every output share is 0x00.
- R9: When the share count is even (odd ORDER), one extra 0x63 is folded into share 0, so the recombined output still carries the affine constant exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| x_sh_i | input | 8*(ORDER+1) | Input byte shares, share i in bits 8i+7:8i |
| rnd_i | input | 8*ORDER*(ORDER+1)/2 | Fresh random bytes, consumed each cycle |
| done_o | output | 1 | One-cycle pulse when output shares are valid |
| y_sh_o | output | 8*(ORDER+1) | Output byte shares |

## Verification
The main function runs on all 256 input bytes. Each byte is tried under several random sharings and also under the degenerate sharing with all masks zero. This shows that the result depends only on the shared value and not on how it is split. The zero input is tried on its own, because the power chain maps it to zero and only the affine constant remains. The same sweep also runs on an instance with an even share count, which separates correct constant folding from missing folding. Directed runs check the latency and the single `done_o` pulse, a second start during a run, and output hold after completion.

// File: rtl/masked_sbox_pkg.sv
// Shared field arithmetic and step encoding for the masked S-box sequencer.
// Assumes bytes are elements of GF(2^8) reduced by x^8+x^4+x^3+x+1.
package masked_sbox_pkg;

    localparam logic [7:0] AFF_CONST = 8'h63;

    // Chain steps, in execution order; the sequencer advances by +1.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_SQ     = 4'd1,
        ST_REF_Z  = 4'd2,
        ST_MUL3   = 4'd3,
        ST_P4     = 4'd4,
        ST_REF_W  = 4'd5,
        ST_MUL15  = 4'd6,
        ST_P16    = 4'd7,
        ST_MUL252 = 4'd8,
        ST_MUL254 = 4'd9,
        ST_AFF    = 4'd10
    } step_e;

    // Field multiply by shift-and-add with modular reduction.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // Linear part of the output affine map (rotations of the byte).
    function automatic logic [7:0] aff_lin(input logic [7:0] v);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]};
    endfunction

endpackage

// File: rtl/share_pow.sv
// Raises every share to the power 2^SQUARINGS independently.
// Assumes nothing about the shares; the map is linear so no randomness is used.
module share_pow #(
    parameter int NS        = 3,
    parameter int SQUARINGS = 1
) (
    input  logic [NS-1:0][7:0] a_i,
    output logic [NS-1:0][7:0] y_o
);
    import masked_sbox_pkg::*;

    for (genvar s = 0; s < NS; s++) begin : g_share
        // Repeated squaring of one share.
        always_comb begin
            logic [7:0] v;
            v = a_i[s];
            for (int k = 0; k < SQUARINGS; k++) v = gf_mul(v, v);
            y_o[s] = v;
        end
    end
endmodule

// File: rtl/share_refresh.sv
// Re-randomises a share vector: byte r[i-1] goes into share 0 and share i.
// Assumes NS >= 2 and that rnd_i is fresh in the cycle it is used.
module share_refresh #(
    parameter int NS = 3
) (
    input  logic [NS-1:0][7:0] a_i,
    input  logic [NS-2:0][7:0] rnd_i,
    output logic [NS-1:0][7:0] y_o
);
    // Each random byte cancels in the XOR of the result.
    always_comb begin
        logic [7:0] s0;
        s0 = a_i[0];
        for (int i = 1; i < NS; i++) begin
            s0     = s0 ^ rnd_i[i-1];
            y_o[i] = a_i[i] ^ rnd_i[i-1];
        end
        y_o[0] = s0;
    end
endmodule

// File: rtl/isw_mult.sv
// Masked field multiplication over NS shares with pairwise random bytes.
// Assumes NR = NS*(NS-1)/2 fresh random bytes; one byte per share pair i<j.
module isw_mult #(
    parameter int NS = 3,
    parameter int NR = 3
) (
    input  logic [NS-1:0][7:0] a_i,
    input  logic [NS-1:0][7:0] b_i,
    input  logic [NR-1:0][7:0] rnd_i,
    output logic [NS-1:0][7:0] c_o
);
    import masked_sbox_pkg::*;

    // Diagonal products, then each cross pair masked by its own random byte.
    always_comb begin
        int k;
        k = 0;
        for (int i = 0; i < NS; i++) c_o[i] = gf_mul(a_i[i], b_i[i]);
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                c_o[i] = c_o[i] ^ rnd_i[k];
                c_o[j] = c_o[j] ^ ((rnd_i[k] ^ gf_mul(a_i[i], b_i[j])) ^ gf_mul(a_i[j], b_i[i]));
                k = k + 1;
            end
        end
    end
endmodule

// File: rtl/share_affine.sv
// Applies the S-box affine map to each share; the constant is added per share,
// plus once more on share 0 when NS is even so that it survives recombination.
module share_affine #(
    parameter int NS = 3
) (
    input  logic [NS-1:0][7:0] a_i,
    output logic [NS-1:0][7:0] y_o
);
    import masked_sbox_pkg::*;

    localparam bit FOLD_EXTRA = (NS % 2) == 0;

    for (genvar s = 0; s < NS; s++) begin : g_share
        if (s == 0 && FOLD_EXTRA) begin : g_fold
            // Share 0 with the extra constant: both copies cancel to none.
            assign y_o[s] = aff_lin(a_i[s]);
        end else begin : g_plain
            // Ordinary share: linear map plus the constant.
            assign y_o[s] = aff_lin(a_i[s]) ^ AFF_CONST;
        end
    end
endmodule

// File: rtl/masked_sbox_seq.sv
// Sequencer for the masked S-box: one step of the x^254 chain per cycle,
// then the share-wise affine map. Assumes rnd_i is fresh every cycle and
// ORDER >= 1. start_i is only sampled while idle.
module masked_sbox_seq #(
    parameter  int ORDER = 2,
    localparam int NS    = ORDER + 1,
    localparam int NR    = ORDER * (ORDER + 1) / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NS-1:0][7:0] x_sh_i,
    input  logic [NR-1:0][7:0] rnd_i,
    output logic               done_o,
    output logic [NS-1:0][7:0] y_sh_o
);
    import masked_sbox_pkg::*;

    step_e              step_q;
    logic [NS-1:0][7:0] x_q, z_q, w_q, y_q, out_q;
    logic               done_q;

    logic [NS-1:0][7:0] sq_x, p4_y, p16_y;
    logic [NS-1:0][7:0] ref_in, ref_out;
    logic [NS-1:0][7:0] mul_a, mul_b, mul_c;
    logic [NS-1:0][7:0] aff_out;

    share_pow #(.NS(NS), .SQUARINGS(1)) i_pow2  (.a_i(x_q), .y_o(sq_x));
    share_pow #(.NS(NS), .SQUARINGS(2)) i_pow4  (.a_i(y_q), .y_o(p4_y));
    share_pow #(.NS(NS), .SQUARINGS(4)) i_pow16 (.a_i(y_q), .y_o(p16_y));

    // Refresh operand: z in the first refresh step, w otherwise.
    always_comb ref_in = (step_q == ST_REF_Z) ? z_q : w_q;

    share_refresh #(.NS(NS)) i_refresh (
        .a_i  (ref_in),
        .rnd_i(rnd_i[ORDER-1:0]),
        .y_o  (ref_out)
    );

    // Multiplier operand selection per multiply step.
    always_comb begin
        unique case (step_q)
            ST_MUL3:   begin mul_a = z_q; mul_b = x_q; end
            ST_MUL254: begin mul_a = y_q; mul_b = z_q; end
            default:   begin mul_a = y_q; mul_b = w_q; end
        endcase
    end

    isw_mult #(.NS(NS), .NR(NR)) i_mult (
        .a_i  (mul_a),
        .b_i  (mul_b),
        .rnd_i(rnd_i),
        .c_o  (mul_c)
    );

    share_affine #(.NS(NS)) i_affine (.a_i(y_q), .y_o(aff_out));

    // Step sequencing, share registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            x_q    <= '0;
            z_q    <= '0;
            w_q    <= '0;
            y_q    <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (step_q)
                ST_IDLE: if (start_i) begin
                    x_q    <= x_sh_i;
                    step_q <= ST_SQ;
                end
                ST_SQ:     begin z_q <= sq_x;    step_q <= ST_REF_Z;  end
                ST_REF_Z:  begin z_q <= ref_out; step_q <= ST_MUL3;   end
                ST_MUL3:   begin y_q <= mul_c;   step_q <= ST_P4;     end
                ST_P4:     begin w_q <= p4_y;    step_q <= ST_REF_W;  end
                ST_REF_W:  begin w_q <= ref_out; step_q <= ST_MUL15;  end
                ST_MUL15:  begin y_q <= mul_c;   step_q <= ST_P16;    end
                ST_P16:    begin y_q <= p16_y;   step_q <= ST_MUL252; end
                ST_MUL252: begin y_q <= mul_c;   step_q <= ST_MUL254; end
                ST_MUL254: begin y_q <= mul_c;   step_q <= ST_AFF;    end
                ST_AFF: begin
                    out_q  <= aff_out;
                    done_q <= 1'b1;
                    step_q <= ST_IDLE;
                end
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign y_sh_o = out_q;

    function automatic logic [7:0] xor_sh(input logic [NS-1:0][7:0] v);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < NS; i++) r = r ^ v[i];
        return r;
    endfunction

    // R3: the completion pulse lasts one cycle and follows the affine step.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r3_done_after_aff: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(step_q == ST_AFF));

    // R4: once running, the chain advances one step per cycle whatever start_i does.
    a_r4_chain_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_IDLE && step_q != ST_AFF) |=> (step_q == $past(step_q) + 4'd1));

    // R5: refreshing z keeps the value it carries.
    a_r5_refresh_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_REF_Z) |=> (xor_sh(z_q) == $past(xor_sh(z_q))));

    // R6: the first masked multiply recombines to the field product.
    a_r6_mult_product: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_MUL3) |=> (xor_sh(y_q) == gf_mul($past(xor_sh(z_q)), $past(xor_sh(x_q)))));

    // R7: outputs change only on the completing edge.
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_AFF) |=> $stable(out_q));

endmodule

// File: tb/test_masked_sbox_seq.sv
module test_masked_sbox_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Main instance: order 2 (three shares). Second: order 1 (two shares).
    logic             start = 1'b0;
    logic [2:0][7:0]  xa = '0;
    logic [2:0][7:0]  ra = '0;
    logic             done_a;
    logic [2:0][7:0]  ya;
    logic [1:0][7:0]  xb = '0;
    logic [0:0][7:0]  rb = '0;
    logic             done_b;
    logic [1:0][7:0]  yb;

    masked_sbox_seq #(.ORDER(2)) i_masked_sbox_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x_sh_i(xa),
        .rnd_i(ra), .done_o(done_a), .y_sh_o(ya));

    masked_sbox_seq #(.ORDER(1)) i_masked_sbox_seq_o1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x_sh_i(xb),
        .rnd_i(rb), .done_o(done_b), .y_sh_o(yb));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] sbox [256];

    // Fresh random bytes every cycle.
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) ra[i] = 8'($urandom);
        rb[0] = 8'($urandom);
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0]  t;
        logic [7:0]  r;
        r = 0;
        t = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= t[7:0];
            t = t << 1;
            if (t[8]) t ^= 9'h11b;
        end
        return r;
    endfunction

    // Builds the reference table: brute-force inverse, then bitwise affine.
    task automatic build_table();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, b;
            inv = 0;
            for (int c = 1; c < 256; c++)
                if (fmul(8'(x), 8'(c)) == 8'h01) inv = 8'(c);
            for (int i = 0; i < 8; i++)
                b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
            sbox[x] = b;
        end
    endtask

    function automatic logic [7:0] rec_a();
        return ya[0] ^ ya[1] ^ ya[2];
    endfunction
    function automatic logic [7:0] rec_b();
        return yb[0] ^ yb[1];
    endfunction

    // Share x on both instances; zero_masks selects the trivial sharing.
    task automatic load(input logic [7:0] x, input bit zero_masks);
        if (zero_masks) begin
            xa = '0; xb = '0;
        end else begin
            xa[1] = 8'($urandom); xa[2] = 8'($urandom); xb[1] = 8'($urandom);
        end
        xa[0] = x ^ xa[1] ^ xa[2];
        xb[0] = x ^ xb[1];
    endtask

    // Starts an operation and waits for done; returns latency in edges.
    task automatic run_op(input logic [7:0] x, input bit zero_masks, output int lat);
        @(negedge clk);
        load(x, zero_masks);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 30) begin
            @(negedge clk);
            lat++;
            if (done_a) break;
        end
    endtask

    task automatic t_reset();
        check("R8 done in reset", int'(done_a), 0);
        check("R8 shares in reset", int'(ya), 0);
        check("R8 done in reset (two shares)", int'(done_b), 0);
        check("R8 shares in reset (two shares)", int'(yb), 0);
    endtask

    task automatic t_zero();
        int lat;
        run_op(8'h00, 1'b0, lat);
        check("R2 zero input", int'(rec_a()), 8'h63);
        check("R2 zero input (two shares)", int'(rec_b()), 8'h63);
    endtask

    task automatic t_latency_pulse();
        int lat;
        run_op(8'h53, 1'b0, lat);
        check("R3 latency", lat, LATENCY);
        check("R3 done on second instance", int'(done_b), 1);
        @(negedge clk);
        check("R3 done drops after one cycle", int'(done_a), 0);
    endtask

    task automatic t_sweep(input int rounds, input bit zero_masks);
        for (int r = 0; r < rounds; r++) begin
            for (int x = 0; x < 256; x++) begin
                int lat;
                run_op(8'(x), zero_masks, lat);
                check("R1 sbox value", int'(rec_a()), int'(sbox[x]));
                check("R9 sbox value with even share count", int'(rec_b()), int'(sbox[x]));
            end
        end
    endtask

    task automatic t_busy_start();
        int lat;
        int extra;
        @(negedge clk);
        load(8'hc4, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        load(8'h01, 1'b0);
        start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (lat < 30 && !done_a) begin @(negedge clk); lat++; end
        check("R4 latency unchanged by second start", lat, LATENCY);
        check("R4 result from first operand", int'(rec_a()), int'(sbox[8'hc4]));
        extra = 0;
        repeat (14) begin
            @(negedge clk);
            if (done_a) extra++;
        end
        check("R4 no extra done pulse", extra, 0);
    endtask

    task automatic t_hold();
        int lat;
        logic [2:0][7:0] snap;
        run_op(8'hff, 1'b0, lat);
        snap = ya;
        repeat (6) @(negedge clk);
        check("R7 output shares held", int'(ya == snap), 1);
        check("R7 held value", int'(rec_a()), int'(sbox[8'hff]));
    endtask

    initial begin
        build_table();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_zero();
        t_latency_pulse();
        t_sweep(1, 1'b1);
        t_sweep(3, 1'b0);
        t_busy_start();
        t_hold();
        finish_run();
    end
endmodule